// File: doc/BRIEF.md
# Buck Regulator Start-Up and Fault Sequencer

This block is the digital supervisor beside a synchronous buck controller and a companion linear regulator. Its inputs are single-bit comparator results: bias-supply power good, an enable line, a switch-node-above-threshold flag, an overcurrent flag, a low-side-conducting flag and two feedback undervoltage flags. From these it decides when each regulator may run and what soft-start reference code the error amplifiers see.

Once bias power is good and enable is high, the block checks that the buck input rail is present. It pulses the high-side gate at a slow rate and counts switch-node threshold transitions, both rising and falling. When the rail is found, it waits for a fixed settling delay and then steps a soft-start code linearly to full scale. Both regulators are enabled during this ramp. In the run phase it filters the undervoltage flags and samples overcurrent while the low-side switch conducts.

A buck undervoltage fault stops everything at once. A linear undervoltage fault or an overcurrent trip causes a hiccup, which re-runs the delay and the ramp. A limited number of hiccups leads to a latched halt. The halt clears only when bias power is lost or enable is pulsed low. All times are given in microseconds and scaled by a clock-cycles-per-microsecond parameter.

Top module: `buck_seq`

## Requirements
- R1: While rst_n is low, or in any cycle after the one in which por_ok or en_in was sampled low, probe_gate, sw_en, lin_en and ss_done are 0, ss_code is 0 and fault is 0 (none).
- R2: In the probing phase, which starts one cycle after por_ok and en_in are both sampled high, probe_gate is high for the first PW cycles of every PER-cycle period. PER is PROBE_PERIOD_US*CYC_PER_US and PW is PROBE_WIDTH_US*CYC_PER_US. probe_gate is low in every other phase.
- R3: During probing, every cycle in which phase_hi differs from its value in the previous cycle counts as one transition. On the EDGE_COUNT-th transition, probing ends and the delay phase begins. Fewer transitions keep the block probing.
- R4: The delay phase lasts SS_DELAY_US*CYC_PER_US cycles, with sw_en low and ss_code 0. Then sw_en rises and ss_code rises by one every STEP cycles, where STEP is max(1, (SS_RAMP_US*CYC_PER_US) >> SS_W). When ss_code reaches all ones it saturates and ss_done is high from that cycle on.
- R5: lin_en is high exactly when sw_en is high, so the linear regulator follows the same soft-start ramp.
- R6: The undervoltage flags are acted on only while ss_done is high. A flag counts as a fault only on its UV = UV_FILT_US*CYC_PER_US-th consecutive high sample. Shorter pulses, and any pulse during the delay or the ramp, have no effect.
- R7: A buck undervoltage fault (fb_uv) moves the block straight to the latched halt: all enables go low, ss_code goes to 0 and fault reads 1.
- R8: A linear undervoltage fault (fbl_uv) is a hiccup: the enables drop, ss_code returns to 0, and the delay and ramp run again. The HICCUP_LIMIT-th such fault enters the latched halt with fault reading 2.
- R9: oc_trip is sampled only when ls_on is high, during the ramp or the run phase. Each trip is a hiccup as in R8, counted separately. The HICCUP_LIMIT-th trip enters the latched halt with fault reading 3.
- R10: The halt and its fault code persist while por_ok and en_in stay high. A low on either clears the halt and both hiccup counts, and the block then starts again from probing.
- R11: When events coincide in one cycle, the order of priority is: por_ok/en_in low, then buck undervoltage, then overcurrent, then linear undervoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Bias supply above its power-on threshold |
| en_in | input | 1 | Enable; low disables both regulators |
| phase_hi | input | 1 | Switch node above the detection threshold |
| ls_on | input | 1 | Low-side switch is conducting |
| oc_trip | input | 1 | Low-side drop beyond the overcurrent threshold |
| fb_uv | input | 1 | Buck feedback below half of its reference |
| fbl_uv | input | 1 | Linear feedback below half of its reference |
| probe_gate | output | 1 | High-side gate request for rail detection pulses |
| ss_code | output | SS_W | Soft-start reference code |
| sw_en | output | 1 | Buck switching enable |
| lin_en | output | 1 | Linear regulator enable |
| ss_done | output | 1 | Soft-start complete, code at full scale |
| fault | output | 2 | Latched fault: 0 none, 1 buck UV, 2 linear UV limit, 3 overcurrent limit |

## Verification
A wrong phase register shows on the enables, probe_gate or ss_done in the very next cycle. A timer or ramp counter that is off by one shifts the sw_en rising edge or an ss_code step by that cycle. Every output is therefore compared against an independent model on each clock. Errors in the hiccup or undervoltage counters stay hidden until the next trip: they show as a halt one hiccup early or late, or a restart after 59 or 61 high samples instead of 60. Directed sequences therefore drive each limit exactly and probe one sample short of it.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PROBE = 3'd1,
    ST_DELAY = 3'd2,
    ST_RAMP  = 3'd3,
    ST_RUN   = 3'd4,
    ST_HALT  = 3'd5
  } seq_st_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_FB_UV  = 2'd1,
    FLT_LIN_UV = 2'd2,
    FLT_OC     = 2'd3
  } flt_t;

  // Index of each undervoltage filter and hiccup counter
  localparam int UV_FB  = 0;
  localparam int UV_LIN = 1;
  localparam int HC_LIN = 0;
  localparam int HC_OC  = 1;

endpackage

// File: rtl/buck_seq_probe.sv
// Rail detection: periodic gate pulses and switch-node transition counting.
module buck_seq_probe #(
  parameter int PER_CYC = 25000,
  parameter int PW_CYC  = 250,
  parameter int EDGES   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic phase_hi,
  output logic gate,
  output logic found
);
  localparam int TW = $clog2(PER_CYC + 1);
  localparam int EW = $clog2(EDGES + 1);

  logic [TW-1:0] tmr;
  logic [EW-1:0] cnt;
  logic          phase_q;
  logic          edge_ev;

  assign edge_ev = active && (phase_hi != phase_q);
  assign found   = edge_ev && (cnt == EW'(EDGES - 1));
  assign gate    = active && (tmr < TW'(PW_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      cnt     <= '0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_hi;
      if (!active) begin
        tmr <= '0;
        cnt <= '0;
      end else begin
        tmr <= (tmr == TW'(PER_CYC - 1)) ? '0 : tmr + 1'b1;
        if (edge_ev) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buck_seq_ramp.sv
// Settling delay followed by a linear, saturating soft-start code.
module buck_seq_ramp #(
  parameter int SS_W     = 10,
  parameter int DLY_CYC  = 500000,
  parameter int STEP_CYC = 488
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            in_delay,
  input  logic            in_ramp,
  output logic [SS_W-1:0] code,
  output logic            delay_done,
  output logic            last_step
);
  localparam int BIG = (DLY_CYC > STEP_CYC) ? DLY_CYC : STEP_CYC;
  localparam int TW  = $clog2(BIG + 1);
  localparam logic [SS_W-1:0] TOP = '1;

  logic [TW-1:0] tmr;
  logic          step_tick;

  assign step_tick  = in_ramp && (tmr == TW'(STEP_CYC - 1));
  assign delay_done = in_delay && (tmr == TW'(DLY_CYC - 1));
  assign last_step  = step_tick && (code == TOP - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      code <= '0;
    end else if (clear) begin
      tmr  <= '0;
      code <= '0;
    end else if (in_delay) begin
      tmr <= delay_done ? '0 : tmr + 1'b1;
    end else if (in_ramp) begin
      if (step_tick) begin
        tmr  <= '0;
        code <= code + 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buck_seq_uvf.sv
// Continuous-assertion filter for one undervoltage flag.
module buck_seq_uvf #(
  parameter int FILT_CYC = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [CW-1:0] cnt;

  assign trip = en && flag && (cnt == CW'(FILT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!en || !flag)  cnt <= '0;
    else if (!trip)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/buck_seq_hic.sv
// Hiccup counter: flags the trip that reaches the retry limit.
module buck_seq_hic #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear)          cnt <= '0;
    else if (bump && !last)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/buck_seq.sv
module buck_seq
  import buck_seq_pkg::*;
#(
  parameter int CYC_PER_US      = 250,
  parameter int PROBE_PERIOD_US = 100,
  parameter int PROBE_WIDTH_US  = 1,
  parameter int EDGE_COUNT      = 4,
  parameter int SS_DELAY_US     = 2000,
  parameter int SS_RAMP_US      = 2000,
  parameter int SS_W            = 10,
  parameter int UV_FILT_US      = 30,
  parameter int HICCUP_LIMIT    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_ok,
  input  logic            en_in,
  input  logic            phase_hi,
  input  logic            ls_on,
  input  logic            oc_trip,
  input  logic            fb_uv,
  input  logic            fbl_uv,
  output logic            probe_gate,
  output logic [SS_W-1:0] ss_code,
  output logic            sw_en,
  output logic            lin_en,
  output logic            ss_done,
  output logic [1:0]      fault
);
  localparam int PER_CYC  = PROBE_PERIOD_US * CYC_PER_US;
  localparam int PW_CYC   = PROBE_WIDTH_US * CYC_PER_US;
  localparam int DLY_CYC  = SS_DELAY_US * CYC_PER_US;
  localparam int RAMP_CYC = SS_RAMP_US * CYC_PER_US;
  localparam int STEP_RAW = RAMP_CYC >> SS_W;
  localparam int STEP_CYC = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam int UV_CYC   = UV_FILT_US * CYC_PER_US;

  seq_st_t st, nxt;
  flt_t    fault_q, flt_nxt;

  logic       found, delay_done, last_step, restart, ramp_clr, oc_hit;
  logic [1:0] uv_flag, uv_trip, hic_bump, hic_last;

  // ---------------- rail detection ----------------
  buck_seq_probe #(
    .PER_CYC (PER_CYC),
    .PW_CYC  (PW_CYC),
    .EDGES   (EDGE_COUNT)
  ) u_probe (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (st == ST_PROBE),
    .phase_hi (phase_hi),
    .gate     (probe_gate),
    .found    (found)
  );

  // ---------------- soft-start ----------------
  buck_seq_ramp #(
    .SS_W     (SS_W),
    .DLY_CYC  (DLY_CYC),
    .STEP_CYC (STEP_CYC)
  ) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (ramp_clr),
    .in_delay   (st == ST_DELAY),
    .in_ramp    (st == ST_RAMP),
    .code       (ss_code),
    .delay_done (delay_done),
    .last_step  (last_step)
  );

  // ---------------- supervision ----------------
  assign uv_flag = {fbl_uv, fb_uv};
  assign oc_hit  = oc_trip && ls_on;

  for (genvar g = 0; g < 2; g++) begin : g_sup
    buck_seq_uvf #(.FILT_CYC(UV_CYC)) u_uvf (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (st == ST_RUN),
      .flag  (uv_flag[g]),
      .trip  (uv_trip[g])
    );
    buck_seq_hic #(.LIMIT(HICCUP_LIMIT)) u_hic (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st == ST_OFF),
      .bump  (hic_bump[g]),
      .last  (hic_last[g])
    );
  end

  // ---------------- phase control ----------------
  always_comb begin
    nxt      = st;
    flt_nxt  = FLT_NONE;
    hic_bump = '0;
    restart  = 1'b0;
    if (!por_ok || !en_in) begin
      nxt = ST_OFF;
    end else begin
      case (st)
        ST_OFF:   nxt = ST_PROBE;
        ST_PROBE: if (found) nxt = ST_DELAY;
        ST_DELAY: if (delay_done) nxt = ST_RAMP;
        ST_RAMP, ST_RUN: begin
          if (uv_trip[UV_FB]) begin
            nxt     = ST_HALT;
            flt_nxt = FLT_FB_UV;
          end else if (oc_hit) begin
            hic_bump[HC_OC] = 1'b1;
            if (hic_last[HC_OC]) begin
              nxt     = ST_HALT;
              flt_nxt = FLT_OC;
            end else begin
              nxt     = ST_DELAY;
              restart = 1'b1;
            end
          end else if (uv_trip[UV_LIN]) begin
            hic_bump[HC_LIN] = 1'b1;
            if (hic_last[HC_LIN]) begin
              nxt     = ST_HALT;
              flt_nxt = FLT_LIN_UV;
            end else begin
              nxt     = ST_DELAY;
              restart = 1'b1;
            end
          end else if (st == ST_RAMP && last_step) begin
            nxt = ST_RUN;
          end
        end
        ST_HALT:  nxt = ST_HALT;
        default:  nxt = ST_OFF;
      endcase
    end
  end

  // The ramp is cleared whenever the next phase does not drive it
  assign ramp_clr = restart || !(nxt inside {ST_DELAY, ST_RAMP, ST_RUN});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      fault_q <= FLT_NONE;
    end else begin
      st <= nxt;
      if (flt_nxt != FLT_NONE) fault_q <= flt_nxt;
    end
  end

  assign sw_en   = (st == ST_RAMP) || (st == ST_RUN);
  assign lin_en  = sw_en;
  assign ss_done = (st == ST_RUN);
  assign fault   = (st == ST_HALT) ? fault_q : FLT_NONE;

endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk #(
  parameter int SS_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            por_ok,
  input logic            en_in,
  input logic            fb_uv,
  input logic            probe_gate,
  input logic [SS_W-1:0] ss_code,
  input logic            sw_en,
  input logic            lin_en,
  input logic            ss_done,
  input logic [1:0]      fault
);
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok || !en_in) |=> (!sw_en && !probe_gate && fault == 2'd0 && ss_code == '0));

  a_r2_probe_alone: assert property (@(posedge clk) disable iff (!rst_n)
    probe_gate |-> (!sw_en && !ss_done && fault == 2'd0));

  a_r4_code_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !ss_done) |=>
      (ss_code == $past(ss_code) || ss_code == $past(ss_code) + SS_W'(1) || ss_code == '0));

  a_r4_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (ss_code == '1));

  a_r8_halt_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 2'd0) |-> (!sw_en && !lin_en && !probe_gate));

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 2'd0 && por_ok && en_in) |=> (fault == $past(fault)));

  a_r7_fbuv_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == 2'd1 && $past(fault) != 2'd1) |-> ($past(ss_done) && $past(fb_uv)));
endmodule

bind buck_seq buck_seq_chk #(.SS_W(SS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_ok     (por_ok),
  .en_in      (en_in),
  .fb_uv      (fb_uv),
  .probe_gate (probe_gate),
  .ss_code    (ss_code),
  .sw_en      (sw_en),
  .lin_en     (lin_en),
  .ss_done    (ss_done),
  .fault      (fault)
);

// File: tb/sim_buck_seq.sv
`timescale 1ns/1ps
module sim_buck_seq;
  localparam int CPU   = 2;
  localparam int PERU  = 20;
  localparam int PWU   = 1;
  localparam int DLYU  = 50;
  localparam int RMPU  = 64;
  localparam int UVU   = 30;
  localparam int SSW   = 4;
  localparam int PER   = PERU * CPU;          // 40
  localparam int PW    = PWU * CPU;           // 2
  localparam int DLY   = DLYU * CPU;          // 100
  localparam int STEP  = (RMPU * CPU) >> SSW; // 8
  localparam int UVC   = UVU * CPU;           // 60
  localparam int MAXC  = (1 << SSW) - 1;      // 15

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok = 1'b0, en_in = 1'b0, phase_hi = 1'b0, ls_on = 1'b0;
  logic oc_trip = 1'b0, fb_uv = 1'b0, fbl_uv = 1'b0;
  logic probe_gate, sw_en, lin_en, ss_done;
  logic [SSW-1:0] ss_code;
  logic [1:0] fault;

  int tests = 0, fails = 0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  buck_seq #(
    .CYC_PER_US(CPU), .PROBE_PERIOD_US(PERU), .PROBE_WIDTH_US(PWU),
    .EDGE_COUNT(4), .SS_DELAY_US(DLYU), .SS_RAMP_US(RMPU), .SS_W(SSW),
    .UV_FILT_US(UVU), .HICCUP_LIMIT(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_in(en_in),
    .phase_hi(phase_hi), .ls_on(ls_on), .oc_trip(oc_trip),
    .fb_uv(fb_uv), .fbl_uv(fbl_uv), .probe_gate(probe_gate),
    .ss_code(ss_code), .sw_en(sw_en), .lin_en(lin_en),
    .ss_done(ss_done), .fault(fault)
  );

  // ---------------- behavioural reference model ----------------
  // phases: 0 off, 1 probing, 2 delay, 3 ramp, 4 run, 5 halt
  int ms, ptm, edges, dt, code, uvb, uvl, hl, ho, mflt;
  bit prev;

  always @(posedge clk) begin
    bit ev, och;
    if (!rst_n) begin
      ms = 0; ptm = 0; edges = 0; dt = 0; code = 0;
      uvb = 0; uvl = 0; hl = 0; ho = 0; mflt = 0; prev = 1'b0;
    end else begin
      ev = (phase_hi != prev);
      prev = phase_hi;
      if (!por_ok || !en_in) begin
        ms = 0; ptm = 0; edges = 0; dt = 0; code = 0;
        uvb = 0; uvl = 0; hl = 0; ho = 0;
      end else begin
        case (ms)
          0: begin ms = 1; ptm = 0; edges = 0; end
          1: begin
            if (ev) edges++;
            if (ev && edges == 4) begin ms = 2; dt = 0; code = 0; end
            else ptm = (ptm + 1) % PER;
          end
          2: if (dt == DLY - 1) begin ms = 3; dt = 0; end else dt++;
          3, 4: begin
            och = oc_trip && ls_on;
            if (ms == 4) begin
              uvb = fb_uv  ? uvb + 1 : 0;
              uvl = fbl_uv ? uvl + 1 : 0;
            end else begin
              uvb = 0; uvl = 0;
            end
            if (uvb == UVC) begin ms = 5; mflt = 1; end
            else if (och) begin
              ho++;
              if (ho == 4) begin ms = 5; mflt = 3; end else ms = 2;
            end else if (uvl == UVC) begin
              hl++;
              if (hl == 4) begin ms = 5; mflt = 2; end else ms = 2;
            end else if (ms == 3) begin
              dt++;
              if (dt == STEP) begin
                dt = 0; code++;
                if (code == MAXC) ms = 4;
              end
            end
            if (ms == 2 || ms == 5) begin dt = 0; code = 0; uvb = 0; uvl = 0; end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    bit eg, es, ed;
    int ef;
    if (running) begin
      eg = (ms == 1) && (ptm < PW);
      es = (ms == 3) || (ms == 4);
      ed = (ms == 4);
      ef = (ms == 5) ? mflt : 0;
      tests++;
      if (probe_gate !== eg) begin
        fails++; $display("FAIL R2 probe_gate got %0d expected %0d", probe_gate, eg);
      end else if (int'(ss_code) != code) begin
        fails++; $display("FAIL R4 ss_code got %0d expected %0d", ss_code, code);
      end else if (sw_en !== es) begin
        fails++; $display("FAIL R4 sw_en got %0d expected %0d", sw_en, es);
      end else if (lin_en !== es) begin
        fails++; $display("FAIL R5 lin_en got %0d expected %0d", lin_en, es);
      end else if (ss_done !== ed) begin
        fails++; $display("FAIL R4 ss_done got %0d expected %0d", ss_done, ed);
      end else if (int'(fault) != ef) begin
        fails++; $display("FAIL R8 fault got %0d expected %0d", fault, ef);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_phase(input int n);
    for (int i = 0; i < n; i++) begin
      phase_hi = ~phase_hi;
      tick(3);
    end
  endtask

  task automatic gate_count(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (probe_gate) c++;
      tick(1);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !ss_done; i++) tick(1);
  endtask

  task automatic power_up();
    por_ok = 1'b1; en_in = 1'b1;
    tick(3);
    toggle_phase(4);
    wait_done();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    int c;
    tick(5);
    chk(!sw_en && !probe_gate && fault == 2'd0, "R1 reset outputs", sw_en, 0);
    rst_n = 1'b1; en_in = 1'b1; por_ok = 1'b0;
    running = 1'b1;
    tick(20);
    chk(!probe_gate && !sw_en, "R1 no start without por", probe_gate, 0);

    por_ok = 1'b1;
    tick(2);
    gate_count(80, c);
    chk(c == 2 * PW, "R2 probe pulses per two periods", c, 2 * PW);

    toggle_phase(3);
    gate_count(PER, c);
    chk(c == PW && !sw_en, "R3 three transitions keep probing", c, PW);
    toggle_phase(1);
    gate_count(PER, c);
    chk(c == 0 && !sw_en, "R3 fourth transition ends probing", c, 0);

    wait_done();
    chk(ss_done && int'(ss_code) == MAXC, "R4 ramp saturates", ss_code, MAXC);
    chk(lin_en == 1'b1, "R5 linear enabled with ramp", lin_en, 1);

    fb_uv = 1'b1; tick(40); fb_uv = 1'b0; tick(5);
    chk(sw_en && fault == 2'd0, "R6 short uv pulse ignored", fault, 0);

    oc_trip = 1'b1; ls_on = 1'b0; tick(5); oc_trip = 1'b0;
    chk(sw_en && ss_done, "R9 oc ignored without low-side", sw_en, 1);

    for (int k = 1; k <= 4; k++) begin
      oc_trip = 1'b1; ls_on = 1'b1; tick(1);
      oc_trip = 1'b0; ls_on = 1'b0; tick(1);
      if (k < 4) begin
        chk(!sw_en && ss_code == '0 && fault == 2'd0, "R9 oc hiccup restarts", sw_en, 0);
        if (k == 2) begin
          tick(DLY + 5);
          fbl_uv = 1'b1; tick(UVC + 10); fbl_uv = 1'b0;
          chk(sw_en && !ss_done && fault == 2'd0, "R6 uv ignored during ramp", sw_en, 1);
        end
        wait_done();
      end
    end
    chk(fault == 2'd3, "R9 oc limit halts", fault, 3);
    tick(10);
    chk(fault == 2'd3 && !sw_en, "R10 halt is sticky", fault, 3);

    en_in = 1'b0; tick(2);
    chk(fault == 2'd0 && !sw_en, "R10 enable low clears halt", fault, 0);
    power_up();
    chk(ss_done, "R10 restart after enable pulse", ss_done, 1);

    for (int k = 1; k <= 4; k++) begin
      fbl_uv = 1'b1; tick(UVC + 2); fbl_uv = 1'b0;
      if (k < 4) begin
        chk(!sw_en && fault == 2'd0, "R8 linear uv hiccup", sw_en, 0);
        wait_done();
      end
    end
    chk(fault == 2'd2, "R8 linear uv limit halts", fault, 2);

    por_ok = 1'b0; tick(2);
    chk(fault == 2'd0, "R10 por loss clears halt", fault, 0);
    power_up();

    fb_uv = 1'b1; tick(UVC - 1);
    chk(sw_en && fault == 2'd0, "R6 one sample short of filter", fault, 0);
    tick(2);
    chk(fault == 2'd1 && !sw_en && ss_code == '0, "R7 buck uv halts", fault, 1);
    fb_uv = 1'b0;

    en_in = 1'b0; tick(2); power_up();
    fb_uv = 1'b1; fbl_uv = 1'b1; tick(UVC - 1);
    oc_trip = 1'b1; ls_on = 1'b1; tick(1);
    oc_trip = 1'b0; ls_on = 1'b0; fb_uv = 1'b0; fbl_uv = 1'b0;
    chk(fault == 2'd1, "R11 buck uv outranks oc and linear uv", fault, 1);

    en_in = 1'b0; tick(2); power_up();
    fb_uv = 1'b1; tick(UVC - 1);
    en_in = 1'b0; tick(1);
    chk(fault == 2'd0 && !sw_en, "R11 enable low outranks buck uv", fault, 0);
    fb_uv = 1'b0; tick(3);
    chk(!probe_gate && !sw_en && ss_code == '0, "R1 held off while enable low", sw_en, 0);

    running = 1'b0;
    summary();
    $finish;
  end
endmodule